// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block runs one SDRAM command sequence in which a READ burst is cut short by a WRITE. One request carries a read address, the number of read beats wanted, a write address and a full burst of write data. The block then issues READ, the required NOPs, and WRITE on the command pins. It raises DQM early enough that read beats still coming from the memory are masked before the write data goes out. It captures only the wanted read beats, and drives the shared data bus only while write beats are being presented.

The CAS latency, burst length and an optional extra idle cycle for slow bus release are set by parameters. Cycle numbers below count from the READ cycle, which is cycle 0. The READ goes out in the cycle after the edge that accepts the request. Let L be the clamped number of wanted read beats, and let W be the WRITE cycle, W = CL + L + EXTRA_NOP.

Top module: `sdram_rtw`

## Requirements
- R1: During and after reset, before any request: command NOP, `sd_dqm` low, `dq_oe` low, `busy` low, `rd_valid` low.
- R2: Commands on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} are NOP=0111, READ=0101, WRITE=0100. A request accepted while idle puts READ out in cycle 0 with the read bank and column on `sd_ba`/`sd_addr`. `busy` is high from cycle 0 through the last write beat.
- R3: WRITE goes out in cycle W with the write bank and column, and every cycle between READ and WRITE is a NOP.
- R4: With BL>1, `sd_dqm` is high exactly in cycles CL+L-2 through W-1 and low in all other cycles.
- R5: With BL=1, `sd_dqm` is never asserted.
- R6: In cycles W to W+BL-1, `dq_oe` is high and `dq_out` carries write word i (bits i*DW upward of `req_wr_data`) in cycle W+i. `dq_oe` is low in every other cycle.
- R7: `rd_valid` is high in cycle c+1 exactly when cycle c is one of CL..CL+L-1, and `rd_data` then equals `dq_in` of cycle c. Masked beats are never captured.
- R8: A wanted read length of 0 is treated as 1, and one above BL is treated as BL.
- R9: `dq_oe` is never high in a cycle where the memory drives read data. A beat is driven when it lies in the burst, DQM two cycles earlier was low, and the WRITE has not yet been issued. With BL>1, every WRITE is preceded by DQM high in the previous cycle.
- R10: A request made while `busy` is high is ignored and leaves the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a read-then-write sequence |
| req_rd_len | input | LW | Number of read beats wanted |
| req_rd_bank | input | BW | Read bank |
| req_rd_col | input | CW | Read column |
| req_wr_bank | input | BW | Write bank |
| req_wr_col | input | CW | Write column |
| req_wr_data | input | BL*DW | Write burst, word 0 in the low bits |
| busy | output | 1 | Sequence in progress |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BW | Bank address |
| sd_addr | output | CW | Column address |
| sd_dqm | output | 1 | Data mask |
| dq_in | input | DW | Data bus as seen by the controller |
| dq_out | output | DW | Write data toward the bus |
| dq_oe | output | 1 | Controller drives the bus |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | DW | Captured read word |

## Verification
Masking the tail of the read burst and driving the first write beat can meet in the same cycle: cycle W, where the memory's next beat would appear while the controller starts to drive. The bench reaches this with every wanted length from 1 to BL and with clamped lengths. It runs three parameter sets (no gap, extra gap with a shorter latency, and burst of one). A memory model drives each beat only if DQM two cycles earlier was low and no WRITE has been issued. Any cycle where that model and `dq_oe` are both active is judged a failure, as is any masked beat that still reaches `rd_valid`.

// File: rtl/sdram_rtw_pkg.sv
package sdram_rtw_pkg;
    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;
endpackage

// File: rtl/rtw_sched.sv
// Pure schedule: given the cycle index of a sequence and the wanted
// read length, says what the command bus and data pins should do.
module rtw_sched
    import sdram_rtw_pkg::*;
#(
    parameter int CL        = 3,
    parameter int BL        = 4,
    parameter int EXTRA_NOP = 0,
    parameter int LW        = 3,
    parameter int CNTW      = 5,
    parameter int BIW       = 2
) (
    input  logic [CNTW-1:0] t,
    input  logic [LW-1:0]   len,
    output sd_cmd_e         cmd,
    output logic            dqm,
    output logic            wr_beat,
    output logic [BIW-1:0]  beat,
    output logic            rd_win,
    output logic            last
);
    int ti, li, tw;

    always_comb begin
        ti = int'(t);
        li = int'(len);
        tw = CL + li + EXTRA_NOP;
        if (ti == 0)       cmd = CMD_READ;
        else if (ti == tw) cmd = CMD_WRITE;
        else               cmd = CMD_NOP;
        wr_beat = (ti >= tw) && (ti < tw + BL);
        beat    = wr_beat ? BIW'(ti - tw) : '0;
        rd_win  = (ti >= CL) && (ti < tw) && (ti < CL + BL);
        last    = (ti == tw + BL - 1);
    end

    // The mask window only exists when a burst can outlive the read.
    generate
        if (BL > 1) begin : g_mask
            assign dqm = (ti >= CL + li - 2) && (ti < tw);
        end else begin : g_nomask
            assign dqm = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rtw_capture.sv
// Read capture: a beat is taken only inside the read window and only
// when the mask issued two cycles earlier was low.
module rtw_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dqm,
    input  logic          win,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          p1;
        logic          p2;
        logic          vld;
        logic [DW-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.p1  = dqm;
        cap_d.p2  = cap_q.p1;
        cap_d.vld = win && !cap_q.p2;
        if (cap_d.vld) cap_d.dat = dq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_valid = cap_q.vld;
    assign rd_data  = cap_q.dat;
endmodule

// File: rtl/sdram_rtw.sv
module sdram_rtw
    import sdram_rtw_pkg::*;
#(
    parameter int CL        = 3,
    parameter int BL        = 4,
    parameter int EXTRA_NOP = 0,
    parameter int DW        = 16,
    parameter int BW        = 2,
    parameter int CW        = 8,
    localparam int LW       = $clog2(BL) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [LW-1:0]   req_rd_len,
    input  logic [BW-1:0]   req_rd_bank,
    input  logic [CW-1:0]   req_rd_col,
    input  logic [BW-1:0]   req_wr_bank,
    input  logic [CW-1:0]   req_wr_col,
    input  logic [BL*DW-1:0] req_wr_data,
    output logic            busy,
    output logic            sd_cs_n,
    output logic            sd_ras_n,
    output logic            sd_cas_n,
    output logic            sd_we_n,
    output logic [BW-1:0]   sd_ba,
    output logic [CW-1:0]   sd_addr,
    output logic            sd_dqm,
    input  logic [DW-1:0]   dq_in,
    output logic [DW-1:0]   dq_out,
    output logic            dq_oe,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data
);
    localparam int CNTW = $clog2(CL + 2 * BL + 2) + 1;
    localparam int BIW  = (BL > 1) ? $clog2(BL) : 1;

    typedef struct packed {
        logic            run;
        logic            last;
        logic            win;
        logic [CNTW-1:0] cnt;
        logic [LW-1:0]   len;
        logic [BW-1:0]   rbank;
        logic [CW-1:0]   rcol;
        logic [BW-1:0]   wbank;
        logic [CW-1:0]   wcol;
        logic [BL*DW-1:0] wdata;
        sd_cmd_e         cmd;
        logic [BW-1:0]   ba;
        logic [CW-1:0]   addr;
        logic            dqm;
        logic            oe;
        logic [DW-1:0]   dout;
    } st_t;

    st_t st_d, st_q;

    logic            start;
    logic [LW-1:0]   len_n;
    logic [CNTW-1:0] t_n;
    sd_cmd_e         s_cmd;
    logic            s_dqm, s_wr, s_win, s_last;
    logic [BIW-1:0]  s_beat;

    // Next cycle index and clamped length feed the schedule.
    always_comb begin
        start = !st_q.run && req;
        if (!start)                         len_n = st_q.len;
        else if (req_rd_len == '0)          len_n = LW'(1);
        else if (req_rd_len > LW'(BL))      len_n = LW'(BL);
        else                                len_n = req_rd_len;
        t_n = start ? '0 : st_q.cnt + 1'b1;
    end

    rtw_sched #(
        .CL(CL), .BL(BL), .EXTRA_NOP(EXTRA_NOP),
        .LW(LW), .CNTW(CNTW), .BIW(BIW)
    ) u_sched (
        .t(t_n), .len(len_n), .cmd(s_cmd), .dqm(s_dqm),
        .wr_beat(s_wr), .beat(s_beat), .rd_win(s_win), .last(s_last)
    );

    always_comb begin
        logic act;
        st_d = st_q;
        act  = start || (st_q.run && !st_q.last);
        if (start) begin
            st_d.len   = len_n;
            st_d.rbank = req_rd_bank;
            st_d.rcol  = req_rd_col;
            st_d.wbank = req_wr_bank;
            st_d.wcol  = req_wr_col;
            st_d.wdata = req_wr_data;
        end
        st_d.run  = act;
        st_d.cnt  = act ? t_n : '0;
        st_d.last = act && s_last;
        st_d.win  = act && s_win;
        st_d.cmd  = act ? s_cmd : CMD_NOP;
        st_d.dqm  = act && s_dqm;
        st_d.oe   = act && s_wr;
        st_d.ba   = '0;
        st_d.addr = '0;
        if (st_d.cmd == CMD_READ) begin
            st_d.ba   = st_d.rbank;
            st_d.addr = st_d.rcol;
        end else if (st_d.cmd == CMD_WRITE) begin
            st_d.ba   = st_d.wbank;
            st_d.addr = st_d.wcol;
        end
        st_d.dout = st_d.oe ? st_d.wdata[int'(s_beat)*DW +: DW] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmd <= CMD_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    rtw_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .dqm(st_q.dqm), .win(st_q.win),
        .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign busy = st_q.run;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = st_q.cmd;
    assign sd_ba   = st_q.ba;
    assign sd_addr = st_q.addr;
    assign sd_dqm  = st_q.dqm;
    assign dq_oe   = st_q.oe;
    assign dq_out  = st_q.dout;
endmodule

// File: rtl/sdram_rtw_chk.sv
module sdram_rtw_chk #(
    parameter int BL = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_dqm,
    input logic dq_oe,
    input logic rd_valid
);
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0111 || cmd == 4'b0101 || cmd == 4'b0100);

    a_r2_start_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd == 4'b0101);

    a_r3_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0100 |-> busy && dq_oe);

    a_r6_drive_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !sd_dqm);

    a_r7_capture_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(busy));

    generate
        if (BL > 1) begin : g_multi
            a_r9_mask_before_write: assert property (@(posedge clk) disable iff (!rst_n)
                cmd == 4'b0100 |-> $past(sd_dqm));
        end else begin : g_single
            a_r5_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
                !sd_dqm);
        end
    endgenerate
endmodule

bind sdram_rtw sdram_rtw_chk #(.BL(BL)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_dqm(sd_dqm), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/tb_sdram_rtw.sv
module tb_sdram_rtw;
    localparam int NI = 3;
    localparam int CLV[NI] = '{3, 2, 3};
    localparam int BLV[NI] = '{4, 4, 1};
    localparam int XV[NI]  = '{0, 1, 0};
    localparam int NV = 8;
    // {ignore-test, len[3:0], rbank[1:0], rcol[7:0], wbank[1:0], wcol[7:0]}
    localparam logic [24:0] VEC[NV] = '{
        {1'b0, 4'd1, 2'd0, 8'h10, 2'd3, 8'h20},
        {1'b0, 4'd2, 2'd1, 8'h11, 2'd2, 8'h21},
        {1'b0, 4'd3, 2'd2, 8'h12, 2'd1, 8'h22},
        {1'b0, 4'd4, 2'd3, 8'h13, 2'd0, 8'h23},
        {1'b0, 4'd0, 2'd1, 8'h14, 2'd1, 8'h24},
        {1'b0, 4'd7, 2'd2, 8'h15, 2'd3, 8'h25},
        {1'b1, 4'd2, 2'd0, 8'h16, 2'd2, 8'h26},
        {1'b1, 4'd1, 2'd3, 8'h17, 2'd0, 8'h27}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [3:0]  rd_len = '0;
    logic [1:0]  rbank = '0, wbank = '0;
    logic [7:0]  rcol = '0, wcol = '0;
    logic [63:0] wdata = '0;

    logic [3:0]  cmd_w [NI];
    logic        dqm_w [NI], oe_w [NI], busy_w [NI], rv_w [NI];
    logic [15:0] dout_w [NI], rdat_w [NI], dqin_w [NI];
    logic [1:0]  ba_w [NI];
    logic [7:0]  addr_w [NI];

    int checks = 0, fails = 0;
    bit done = 0;
    bit hist [NI][20];

    always #4 clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : gen_i
        localparam int LWG = $clog2(BLV[g]) + 1;
        sdram_rtw #(.CL(CLV[g]), .BL(BLV[g]), .EXTRA_NOP(XV[g])) dut (
            .clk(clk), .rst_n(rst_n), .req(req),
            .req_rd_len(rd_len[LWG-1:0]), .req_rd_bank(rbank), .req_rd_col(rcol),
            .req_wr_bank(wbank), .req_wr_col(wcol),
            .req_wr_data(wdata[BLV[g]*16-1:0]),
            .busy(busy_w[g]),
            .sd_cs_n(cmd_w[g][3]), .sd_ras_n(cmd_w[g][2]),
            .sd_cas_n(cmd_w[g][1]), .sd_we_n(cmd_w[g][0]),
            .sd_ba(ba_w[g]), .sd_addr(addr_w[g]), .sd_dqm(dqm_w[g]),
            .dq_in(dqin_w[g]), .dq_out(dout_w[g]), .dq_oe(oe_w[g]),
            .rd_valid(rv_w[g]), .rd_data(rdat_w[g])
        );
    end

    task automatic chk(input bit ok, input string rq, input int g, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s inst=%0d t=%0t actual=%0h expected=%0h", rq, g, $time, act, exp);
        end
    endtask

    function automatic int clamp_len(input int len, input int bl);
        int lw = $clog2(bl) + 1;
        int m  = len & ((1 << lw) - 1);
        if (m == 0) return 1;
        if (m > bl) return bl;
        return m;
    endfunction

    function automatic logic [15:0] pat(input int v, input int c);
        return 16'hA000 | 16'(v << 8) | 16'(c);
    endfunction

    task automatic run_vec(input int v);
        logic [24:0] e = VEC[v];
        bit   ign = e[24];
        int   len = int'(e[23:20]);
        bit   clampv = (len == 0) || (len > 4);
        string tt = clampv ? "R8" : "R3";
        string tc = ign ? "R10" : "R2";
        @(negedge clk);
        req = 1'b1; rd_len = e[23:20]; rbank = e[19:18]; rcol = e[17:10];
        wbank = e[9:8]; wcol = e[7:0];
        for (int i = 0; i < 4; i++) wdata[i*16 +: 16] = 16'h5000 + 16'(v * 16 + i);
        @(negedge clk);
        req = 1'b0;
        for (int t = 0; t <= 13; t++) begin
            for (int g = 0; g < NI; g++) begin
                int cl = CLV[g], bl = BLV[g];
                int L  = clamp_len(len, bl);
                int tw = cl + L + XV[g];
                int en = tw + bl - 1;
                logic [3:0] ec = (t == 0) ? 4'b0101 : (t == tw) ? 4'b0100 : 4'b0111;
                bit edqm = (bl > 1) && (t >= cl + L - 2) && (t < tw);
                bit eoe  = (t >= tw) && (t <= en);
                bit erv  = (t - 1 >= cl) && (t - 1 <= cl + L - 1);
                bit drive;
                hist[g][t] = dqm_w[g];
                chk(cmd_w[g] == ec, (t == tw) ? tt : tc, g, cmd_w[g], ec);
                if (t == 0) begin
                    chk(ba_w[g] == e[19:18] && addr_w[g] == e[17:10], "R2", g,
                        {ba_w[g], addr_w[g]}, {e[19:18], e[17:10]});
                end
                if (t == tw) begin
                    chk(ba_w[g] == e[9:8] && addr_w[g] == e[7:0], "R3", g,
                        {ba_w[g], addr_w[g]}, {e[9:8], e[7:0]});
                    if (bl > 1) chk(hist[g][t-1] == 1'b1, "R9", g, hist[g][t-1], 1);
                end
                chk(busy_w[g] == (t <= en), tc, g, busy_w[g], (t <= en));
                chk(dqm_w[g] == edqm, (bl > 1) ? "R4" : "R5", g, dqm_w[g], edqm);
                chk(oe_w[g] == eoe, "R6", g, oe_w[g], eoe);
                if (eoe) chk(dout_w[g] == 16'h5000 + 16'(v * 16 + t - tw), "R6", g,
                             dout_w[g], 16'h5000 + 16'(v * 16 + t - tw));
                chk(rv_w[g] == erv, clampv ? "R8" : "R7", g, rv_w[g], erv);
                if (erv) chk(rdat_w[g] == pat(v, t - 1), "R7", g, rdat_w[g], pat(v, t - 1));
                drive = (t >= cl) && (t < cl + bl) && (t <= tw) && (t < 2 || !hist[g][t-2]);
                chk(!(drive && oe_w[g]), "R9", g, {drive, oe_w[g]}, 0);
                dqin_w[g] = drive ? pat(v, t) : 16'hDEAD;
            end
            if (ign && t == 2) begin
                req = 1'b1; rd_len = 4'd3; rbank = ~e[19:18]; rcol = 8'hEE;
                wbank = ~e[9:8]; wcol = 8'hDD; wdata = '1;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int g = 0; g < NI; g++) dqin_w[g] = 16'hDEAD;
        repeat (3) @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            chk(cmd_w[g] == 4'b0111, "R1", g, cmd_w[g], 4'b0111);
            chk(!dqm_w[g] && !oe_w[g], "R1", g, {dqm_w[g], oe_w[g]}, 0);
            chk(!busy_w[g] && !rv_w[g], "R1", g, {busy_w[g], rv_w[g]}, 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            chk(cmd_w[g] == 4'b0111 && !busy_w[g], "R1", g, cmd_w[g], 4'b0111);
        end
        for (int v = 0; v < NV; v++) run_vec(v);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule